// File: doc/BRIEF.md
# Processor Power-Mode Sequencer

This block steps a processor core between three steady power modes (full run, clock-stopped idle and powered-down sleep) and drives the core's clock-enable and power-enable lines to match. Every move between modes goes through a transitional state that lasts a fixed number of reference-clock ticks. The entry and exit costs differ: leaving sleep is the slowest move and dropping into sleep is the next slowest. While a move is in progress, the core's clock is held off, its power is held on and the ready flag is low.

The decision to power down comes from an inactivity timer. When the core's busy/request line has been low for a programmable number of cycles, the core leaves run for idle. A second programmable dwell time moves it from idle into sleep. A third dwell time starts a wake-up before any request arrives. A request wakes the core from either low-power mode. A request that arrives while the core is still entering a mode is held until the entry finishes, and the exit then starts at once. A forced-sleep command skips the idle timeout.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the mode is run, with clk_en_o, pwr_en_o and ready_o high, and the inactivity count is zero, so a busy line that goes low at release triggers the idle entry after exactly idle_after_i cycles.
- R2: Outputs by mode: run gives clock 1, power 1, ready 1. Idle gives clock 0, power 1, ready 0. Sleep gives clock 0, power 0, ready 0. Every transitional state gives clock 0, power 1, ready 0.
- R3: In run, the block starts the idle entry on the idle_after_i-th consecutive sampled cycle with busy_i low. Any cycle with busy_i high restarts the count. A value of 0 disables the timeout.
- R4: Each transitional state lasts exactly its latency parameter in cycles: run-to-idle 10, idle-to-run 10, sleep entry 90, sleep-to-run 160 by default. A steady low-power mode is reached only through its entry state, and run is reached again only through an exit state.
- R5: After sleep_after_i cycles in idle, the block starts the sleep entry. A value of 0 disables this move.
- R6: busy_i high in idle or sleep starts the matching exit state at the next edge.
- R7: After wake_after_i cycles in idle or sleep, the block starts the exit without a request. A value of 0 disables this. In idle it takes priority over the sleep timeout when both expire together.
- R8: If busy_i is high during an entry state, that request is kept. When the entry finishes, the block goes straight to the matching exit state instead of the steady mode.
- R9: force_sleep_i in run (or in idle with busy_i low) starts the sleep entry at the next edge. It has no effect in sleep or in any transitional state.
- R10: mode_o encoding: 0 run, 1 run-to-idle, 2 idle, 3 idle-to-run, 4 sleep entry, 5 sleep, 6 sleep-to-run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| busy_i | input | 1 | Core busy / wake request |
| force_sleep_i | input | 1 | Command to enter sleep now |
| idle_after_i | input | CNT_W | Inactive cycles before idle entry (0 = off) |
| sleep_after_i | input | CNT_W | Idle cycles before sleep entry (0 = off) |
| wake_after_i | input | CNT_W | Low-power cycles before predictive wake (0 = off) |
| clk_en_o | output | 1 | Core clock enable |
| pwr_en_o | output | 1 | Core power enable |
| ready_o | output | 1 | High only in steady run |
| mode_o | output | 3 | Current mode code (R10) |

## Verification
The hardest case to reach is a request that lands inside an entry transition. This must send the block straight from entry into exit with no cycle in the steady mode. The stimulus reaches it in two ways: by raising busy_i partway through the run-to-idle window, and by issuing forced sleep while busy_i is still high. The dwell thresholds are reprogrammed between phases, so the same paths are also covered with the sleep timeout alone, with the predictive wake alone, and with both set to the same value.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

   typedef enum logic [2:0] {
      PM_RUN   = 3'd0,
      PM_R2I   = 3'd1,
      PM_IDLE  = 3'd2,
      PM_I2R   = 3'd3,
      PM_S_IN  = 3'd4,
      PM_SLEEP = 3'd5,
      PM_S_OUT = 3'd6
   } pm_state_e;

   localparam int unsigned N_THR   = 3;
   localparam int unsigned THR_RUN = 0;
   localparam int unsigned THR_SLP = 1;
   localparam int unsigned THR_WK  = 2;

   function automatic logic is_entry(pm_state_e s);
      return (s == PM_R2I) || (s == PM_S_IN);
   endfunction

   function automatic logic is_exit(pm_state_e s);
      return (s == PM_I2R) || (s == PM_S_OUT);
   endfunction

   function automatic logic is_trans(pm_state_e s);
      return is_entry(s) || is_exit(s);
   endfunction

endpackage

// File: rtl/pmc_dwell_cnt.sv
module pmc_dwell_cnt #(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned N_THR = 3
) (
   input  logic                        clk_i,
   input  logic                        rst_ni,
   input  logic                        clr_i,
   input  logic                        inc_i,
   input  logic [N_THR-1:0][CNT_W-1:0] thr_i,
   output logic [N_THR-1:0]            hit_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

   if (CNT_W < 2) begin : g_bad_w
      $error("pmc_dwell_cnt: CNT_W must be at least 2");
   end
   if (N_THR < 1) begin : g_bad_n
      $error("pmc_dwell_cnt: N_THR must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (inc_i && (cnt_q != CNT_MAX)) begin
         cnt_q <= cnt_q + ONE;
      end
   end

   // A threshold fires on the sampled cycle that completes it.
   for (genvar g = 0; g < N_THR; g++) begin : g_thr
      assign hit_o[g] = (thr_i[g] != '0) && inc_i && (cnt_q == (thr_i[g] - ONE));
   end

   AST_CNT_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i && inc_i && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX)); // R3

   AST_CNT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> (cnt_q == '0)); // R3

endmodule

// File: rtl/pmc_lat_timer.sv
module pmc_lat_timer
   import pmc_pkg::*;
#(
   parameter int unsigned LAT_W     = 8,
   parameter int unsigned LAT_R2I   = 10,
   parameter int unsigned LAT_I2R   = 10,
   parameter int unsigned LAT_S_IN  = 90,
   parameter int unsigned LAT_S_OUT = 160
) (
   input  logic      clk_i,
   input  logic      rst_ni,
   input  logic      load_i,
   input  pm_state_e sel_i,
   output logic      done_o
);

   localparam int unsigned LAT_CAP = 1 << LAT_W;

   if (LAT_R2I < 1 || LAT_R2I > LAT_CAP) begin : g_bad_r2i
      $error("pmc_lat_timer: LAT_R2I out of range");
   end
   if (LAT_I2R < 1 || LAT_I2R > LAT_CAP) begin : g_bad_i2r
      $error("pmc_lat_timer: LAT_I2R out of range");
   end
   if (LAT_S_IN < 1 || LAT_S_IN > LAT_CAP) begin : g_bad_sin
      $error("pmc_lat_timer: LAT_S_IN out of range");
   end
   if (LAT_S_OUT < 1 || LAT_S_OUT > LAT_CAP) begin : g_bad_sout
      $error("pmc_lat_timer: LAT_S_OUT out of range");
   end

   localparam logic [LAT_W-1:0] LD_R2I   = LAT_W'(LAT_R2I - 1);
   localparam logic [LAT_W-1:0] LD_I2R   = LAT_W'(LAT_I2R - 1);
   localparam logic [LAT_W-1:0] LD_S_IN  = LAT_W'(LAT_S_IN - 1);
   localparam logic [LAT_W-1:0] LD_S_OUT = LAT_W'(LAT_S_OUT - 1);

   logic [LAT_W-1:0] cnt_q;
   logic [LAT_W-1:0] ld_val;

   always_comb begin
      unique case (sel_i)
         PM_R2I:   ld_val = LD_R2I;
         PM_I2R:   ld_val = LD_I2R;
         PM_S_IN:  ld_val = LD_S_IN;
         PM_S_OUT: ld_val = LD_S_OUT;
         default:  ld_val = '0;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= ld_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - LAT_W'(1);
      end
   end

   assign done_o = (cnt_q == '0);

   AST_LAT_HOLD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!load_i && cnt_q == '0) |=> (cnt_q == '0)); // R4

   AST_LAT_DESCENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - LAT_W'(1))); // R4

endmodule

// File: rtl/pmc_out_map.sv
module pmc_out_map
   import pmc_pkg::*;
#(
   parameter bit REG_OUT = 1'b0
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  pm_state_e  state_i,
   output logic       clk_en_o,
   output logic       pwr_en_o,
   output logic       ready_o,
   output logic [2:0] mode_o
);

   logic       clk_en_d;
   logic       pwr_en_d;
   logic       ready_d;
   logic [2:0] mode_d;

   always_comb begin
      clk_en_d = (state_i == PM_RUN);
      ready_d  = (state_i == PM_RUN);
      pwr_en_d = (state_i != PM_SLEEP);
      mode_d   = 3'(state_i);
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            clk_en_o <= 1'b1;
            pwr_en_o <= 1'b1;
            ready_o  <= 1'b1;
            mode_o   <= 3'(PM_RUN);
         end else begin
            clk_en_o <= clk_en_d;
            pwr_en_o <= pwr_en_d;
            ready_o  <= ready_d;
            mode_o   <= mode_d;
         end
      end
   end else begin : g_comb
      assign clk_en_o = clk_en_d;
      assign pwr_en_o = pwr_en_d;
      assign ready_o  = ready_d;
      assign mode_o   = mode_d;
   end

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
   import pmc_pkg::*;
#(
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned LAT_W     = 8,
   parameter int unsigned LAT_R2I   = 10,
   parameter int unsigned LAT_I2R   = 10,
   parameter int unsigned LAT_S_IN  = 90,
   parameter int unsigned LAT_S_OUT = 160,
   parameter bit          REG_OUT   = 1'b0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             busy_i,
   input  logic             force_sleep_i,
   input  logic [CNT_W-1:0] idle_after_i,
   input  logic [CNT_W-1:0] sleep_after_i,
   input  logic [CNT_W-1:0] wake_after_i,
   output logic             clk_en_o,
   output logic             pwr_en_o,
   output logic             ready_o,
   output logic [2:0]       mode_o
);

   pm_state_e state_q, state_d;
   logic      state_chg;
   logic      pend_q;
   logic      lat_done;
   logic      lat_load;
   logic      dw_clr, dw_inc;
   logic [N_THR-1:0][CNT_W-1:0] thr;
   logic [N_THR-1:0]            hit;

   assign thr[THR_RUN] = idle_after_i;
   assign thr[THR_SLP] = sleep_after_i;
   assign thr[THR_WK]  = wake_after_i;

   // ---------------- next-state selection ----------------
   always_comb begin
      state_d = state_q;
      unique case (state_q)
         PM_RUN: begin
            if (force_sleep_i)      state_d = PM_S_IN;
            else if (hit[THR_RUN])  state_d = PM_R2I;
         end
         PM_R2I: begin
            if (lat_done)           state_d = (pend_q || busy_i) ? PM_I2R : PM_IDLE;
         end
         PM_IDLE: begin
            if (busy_i)             state_d = PM_I2R;
            else if (force_sleep_i) state_d = PM_S_IN;
            else if (hit[THR_WK])   state_d = PM_I2R;
            else if (hit[THR_SLP])  state_d = PM_S_IN;
         end
         PM_I2R: begin
            if (lat_done)           state_d = PM_RUN;
         end
         PM_S_IN: begin
            if (lat_done)           state_d = (pend_q || busy_i) ? PM_S_OUT : PM_SLEEP;
         end
         PM_SLEEP: begin
            if (busy_i || hit[THR_WK]) state_d = PM_S_OUT;
         end
         PM_S_OUT: begin
            if (lat_done)           state_d = PM_RUN;
         end
         default:                   state_d = PM_RUN;
      endcase
   end

   assign state_chg = (state_d != state_q);
   assign lat_load  = state_chg && is_trans(state_d);

   // dwell counter: inactivity in run, time spent in idle or sleep
   assign dw_clr = state_chg || ((state_q == PM_RUN) && busy_i);
   assign dw_inc = ((state_q == PM_RUN) && !busy_i) ||
                   (state_q == PM_IDLE) || (state_q == PM_SLEEP);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= PM_RUN;
         pend_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         pend_q  <= state_chg ? 1'b0 : (pend_q || (is_entry(state_q) && busy_i));
      end
   end

   pmc_dwell_cnt #(
      .CNT_W (CNT_W),
      .N_THR (N_THR)
   ) dwell_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (dw_clr),
      .inc_i  (dw_inc),
      .thr_i  (thr),
      .hit_o  (hit)
   );

   pmc_lat_timer #(
      .LAT_W     (LAT_W),
      .LAT_R2I   (LAT_R2I),
      .LAT_I2R   (LAT_I2R),
      .LAT_S_IN  (LAT_S_IN),
      .LAT_S_OUT (LAT_S_OUT)
   ) lat_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (lat_load),
      .sel_i  (state_d),
      .done_o (lat_done)
   );

   pmc_out_map #(
      .REG_OUT (REG_OUT)
   ) out_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .state_i  (state_q),
      .clk_en_o (clk_en_o),
      .pwr_en_o (pwr_en_o),
      .ready_o  (ready_o),
      .mode_o   (mode_o)
   );

   // ---------------- assertions ----------------
   AST_TRANS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (is_trans(state_q) && !lat_done) |=> $stable(state_q)); // R4

   AST_IDLE_VIA_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == PM_IDLE && $past(state_q) != PM_IDLE) |-> ($past(state_q) == PM_R2I)); // R4

   AST_SLEEP_VIA_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == PM_SLEEP && $past(state_q) != PM_SLEEP) |-> ($past(state_q) == PM_S_IN)); // R4

   AST_RUN_VIA_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == PM_RUN && $past(state_q) != PM_RUN) |-> is_exit($past(state_q))); // R6

   AST_PEND_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (is_entry(state_q) && lat_done && pend_q) |=> is_exit(state_q)); // R8

   AST_FORCE_FROM_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == PM_RUN && force_sleep_i) |=> (state_q == PM_S_IN)); // R9

   AST_SLEEP_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == PM_SLEEP && busy_i) |=> (state_q == PM_S_OUT)); // R6

endmodule

// File: tb/pwr_mode_ctrl_tb_top.sv
module pwr_mode_ctrl_tb_top;

   localparam int CNT_W = 16;
   localparam logic [2:0] M_RUN   = 3'd0;
   localparam logic [2:0] M_R2I   = 3'd1;
   localparam logic [2:0] M_IDLE  = 3'd2;
   localparam logic [2:0] M_I2R   = 3'd3;
   localparam logic [2:0] M_S_IN  = 3'd4;
   localparam logic [2:0] M_SLEEP = 3'd5;
   localparam logic [2:0] M_S_OUT = 3'd6;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             busy = 1'b1;
   logic             force_s = 1'b0;
   logic [CNT_W-1:0] idle_after = 16'd5;
   logic [CNT_W-1:0] sleep_after = 16'd0;
   logic [CNT_W-1:0] wake_after = 16'd0;
   logic             clk_en, pwr_en, ready;
   logic [2:0]       mode;

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;
   bit done    = 1'b0;

   int         q_cyc[$];
   logic [2:0] q_mode[$];
   string      q_tag[$];

   always #10 clk = ~clk;

   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   pwr_mode_ctrl dut_i (
      .clk_i         (clk),
      .rst_ni        (rst_n),
      .busy_i        (busy),
      .force_sleep_i (force_s),
      .idle_after_i  (idle_after),
      .sleep_after_i (sleep_after),
      .wake_after_i  (wake_after),
      .clk_en_o      (clk_en),
      .pwr_en_o      (pwr_en),
      .ready_o       (ready),
      .mode_o        (mode)
   );

   // expected {clk_en, pwr_en, ready} per mode code (R2)
   function automatic logic [2:0] exp_lines(logic [2:0] m);
      case (m)
         M_RUN:   return 3'b111;
         M_IDLE:  return 3'b010;
         M_SLEEP: return 3'b000;
         default: return 3'b010;
      endcase
   endfunction

   task automatic check_now(logic [2:0] m, string tag);
      logic [2:0] el;
      el = exp_lines(m);
      n_tests++;
      if (mode !== m || {clk_en, pwr_en, ready} !== el) begin
         n_fail++;
         $display("FAIL %s cyc %0d: mode/clk/pwr/rdy actual %0d/%b expected %0d/%b",
                  tag, cyc, mode, {clk_en, pwr_en, ready}, m, el);
      end
   endtask

   task automatic exp_m(int c, logic [2:0] m, string tag);
      q_cyc.push_back(c);
      q_mode.push_back(m);
      q_tag.push_back(tag);
   endtask

   task automatic go(int c);
      while (cyc < c) @(negedge clk);
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n) begin
         while (q_cyc.size() > 0 && q_cyc[0] <= cyc) begin
            if (q_cyc[0] < cyc) begin
               n_tests++;
               n_fail++;
               $display("FAIL %s: expectation for cyc %0d missed, actual cyc %0d expected cyc %0d",
                        q_tag[0], q_cyc[0], cyc, q_cyc[0]);
            end else begin
               check_now(q_mode[0], q_tag[0]);
            end
            void'(q_cyc.pop_front());
            void'(q_mode.pop_front());
            void'(q_tag.pop_front());
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      check_now(M_RUN, "R1 reset");

      // A1: counter cleared at reset, idle entry, wake from idle
      busy = 1'b0;
      exp_m(4,  M_RUN,  "R1");
      exp_m(5,  M_R2I,  "R3");
      exp_m(14, M_R2I,  "R4");
      exp_m(15, M_IDLE, "R4");
      exp_m(20, M_IDLE, "R2");
      go(25); busy = 1'b1;
      exp_m(26, M_I2R, "R6");
      exp_m(35, M_I2R, "R4");
      exp_m(36, M_RUN, "R4");
      go(40);

      // A2: busy restarts the count; request during entry is kept
      busy = 1'b0;
      exp_m(48, M_RUN,  "R3");
      exp_m(49, M_R2I,  "R3");
      exp_m(58, M_R2I,  "R8");
      exp_m(59, M_I2R,  "R8");
      exp_m(68, M_I2R,  "R4");
      exp_m(69, M_RUN,  "R8");
      go(43); busy = 1'b1;
      go(44); busy = 1'b0;
      go(55); busy = 1'b1;
      go(75);

      // B: idle to sleep by timeout, force ignored in sleep and exit
      sleep_after = 16'd20;
      busy = 1'b0;
      exp_m(109, M_IDLE,  "R5");
      exp_m(110, M_S_IN,  "R5");
      exp_m(150, M_S_IN,  "R2");
      exp_m(199, M_S_IN,  "R4");
      exp_m(200, M_SLEEP, "R4");
      exp_m(220, M_SLEEP, "R2");
      exp_m(240, M_SLEEP, "R9");
      go(230); force_s = 1'b1;
      go(231); force_s = 1'b0;
      go(250); busy = 1'b1;
      exp_m(251, M_S_OUT, "R6");
      exp_m(410, M_S_OUT, "R4");
      exp_m(411, M_RUN,   "R9");
      go(300); force_s = 1'b1;
      go(301); force_s = 1'b0;
      go(420);

      // C: predictive wake from sleep
      wake_after = 16'd30;
      busy = 1'b0;
      exp_m(454, M_IDLE,  "R5");
      exp_m(455, M_S_IN,  "R5");
      exp_m(545, M_SLEEP, "R4");
      exp_m(574, M_SLEEP, "R7");
      exp_m(575, M_S_OUT, "R7");
      exp_m(734, M_S_OUT, "R4");
      exp_m(735, M_RUN,   "R7");
      go(600); busy = 1'b1;
      go(740);

      // D: predictive wake beats sleep timeout in idle
      wake_after  = 16'd8;
      sleep_after = 16'd8;
      busy = 1'b0;
      exp_m(762, M_IDLE, "R7");
      exp_m(763, M_I2R,  "R7");
      exp_m(773, M_RUN,  "R7");
      go(765); busy = 1'b1;
      go(780);

      // E: forced sleep from run while busy, request kept through entry
      wake_after  = 16'd0;
      sleep_after = 16'd0;
      force_s = 1'b1;
      exp_m(781,  M_S_IN,  "R9");
      exp_m(870,  M_S_IN,  "R4");
      exp_m(871,  M_S_OUT, "R8");
      exp_m(1030, M_S_OUT, "R4");
      exp_m(1031, M_RUN,   "R8");
      go(781); force_s = 1'b0;
      go(1040);

      // F: forced sleep from idle, sleep held with predictive wake off
      busy = 1'b0;
      exp_m(1060, M_IDLE,  "R9");
      exp_m(1061, M_S_IN,  "R9");
      exp_m(1150, M_S_IN,  "R4");
      exp_m(1151, M_SLEEP, "R9");
      exp_m(1200, M_SLEEP, "R7");
      go(1060); force_s = 1'b1;
      go(1061); force_s = 1'b0;
      go(1210); busy = 1'b1;
      exp_m(1211, M_S_OUT, "R6");
      exp_m(1371, M_RUN,   "R6");
      go(1380);

      // G: idle timeout disabled
      idle_after = 16'd0;
      busy = 1'b0;
      exp_m(1390, M_RUN, "R3");
      exp_m(1420, M_RUN, "R3");
      exp_m(1440, M_RUN, "R3");
      go(1450);

      if (q_cyc.size() != 0) begin
         n_tests++;
         n_fail++;
         $display("FAIL R10: actual %0d pending expectations expected 0", q_cyc.size());
      end
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule